// File: doc/BRIEF.md
# Accumulator Stored-Program Machine

This block is a small processor whose program and data share a single word-addressed memory. It holds one signed accumulator and one instruction counter. Every instruction takes two neighbouring words: an opcode word, then a parameter word. The parameter is a memory address or a literal, depending on the opcode. The instruction set has seven opcodes:

- load a literal,
- add a memory word,
- subtract a memory word,
- store the accumulator,
- branch when the accumulator is positive,
- read a word from an input stream,
- print a word to an output stream.

Any other opcode value stops the machine. There is no indirect addressing. A program reaches a computed address by storing into the parameter word of one of its own later instructions.

A host fills the memory through a write port while the machine is stopped. It then pulses `start` and waits for `halted`. Input words come in through a valid/ready handshake. Printed words leave as single-cycle valid pulses.

Top module: `spm_top`

## Requirements
- R1: After reset, `halted` is 1 and both `out_valid` and `in_ready` are 0.
- R2: A `start` pulse while halted clears the accumulator, sets the instruction counter to `ENTRY_ADDR` (default 0) and drops `halted` on the next cycle.
- R3: An instruction at address k uses word k as the opcode and word k+1 as the parameter. Every instruction that does not take a branch is followed by the one at k+2.
- R4: Opcode 1 places the parameter itself in the accumulator.
- R5: Opcode 2 adds the memory word at the parameter address to the accumulator. Opcode 3 subtracts that word from it. Both use DATA_W-bit two's complement and wrap on overflow.
- R6: Opcode 4 writes the accumulator to the memory word at the parameter address.
- R7: Opcode 5 moves the instruction counter to the parameter address only when the accumulator, read as signed, is strictly greater than zero. A zero or negative accumulator falls through to k+2.
- R8: Opcode 6 raises `in_ready` and waits with no time limit. The word presented with `in_valid` is written to the parameter address in the cycle where both are 1.
- R9: Opcode 7 presents the memory word at the parameter address on `out_data`, with `out_valid` high for exactly one cycle.
- R10: An opcode word outside the signed range 1 to 7 stops the machine and sets `halted`. This includes negative values and 0.
- R11: A store or read into a later instruction's parameter word takes effect when that instruction runs.
- R12: Loader writes take effect only while `halted` is 1. While the machine runs they are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin execution at the entry address (ignored while running) |
| load_en | input | 1 | Loader write strobe |
| load_addr | input | 8 | Loader word address |
| load_data | input | 16 | Loader word |
| in_valid | input | 1 | Input word available |
| in_data | input | 16 | Input word |
| in_ready | output | 1 | Machine is waiting in a read instruction |
| out_valid | output | 1 | One-cycle strobe for a printed word |
| out_data | output | 16 | Printed word |
| halted | output | 1 | Machine is stopped |

## Verification
Two situations are the hardest to reach from the ports: a program rewriting its own parameter word, and a loader write landing in the middle of a run. The bench covers the first with programs that read an address from the input stream, or store a computed literal, into the parameter of a later print. The printed value shows which address was used. For the second, the bench holds back `in_valid` so the machine stalls in a read. During that stall it tries to overwrite the next opcode with a halting value, then checks that the program still produces all of its outputs.

// File: rtl/spm_pkg.sv
package spm_pkg;

    typedef enum logic [2:0] {
        OP_STOP = 3'd0,
        OP_LIT  = 3'd1,
        OP_ADD  = 3'd2,
        OP_SUB  = 3'd3,
        OP_PUT  = 3'd4,
        OP_BPOS = 3'd5,
        OP_GET  = 3'd6,
        OP_SHOW = 3'd7
    } op_e;

    typedef enum logic [1:0] {
        ST_STOP  = 2'd0,
        ST_FETCH = 2'd1,
        ST_EXEC  = 2'd2
    } st_e;

    localparam int IC_STEP = 2;
    localparam int OPC_MIN = 1;
    localparam int OPC_MAX = 7;

    // Any word outside the legal range maps to OP_STOP.
    function automatic op_e decode_op(input logic legal, input logic [2:0] low);
        return legal ? op_e'(low) : OP_STOP;
    endfunction

endpackage

// File: rtl/spm_store.sv
module spm_store #(
    parameter int DATA_W = 16,
    parameter int ADDR_W = 8,
    parameter int NRD    = 3
) (
    input  logic                     clk,
    input  logic                     we,
    input  logic [ADDR_W-1:0]        wa,
    input  logic [DATA_W-1:0]        wd,
    input  logic [NRD*ADDR_W-1:0]    ra,
    output logic [NRD*DATA_W-1:0]    rd
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] words [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            words[wa] <= wd;
        end
    end

    for (genvar p = 0; p < NRD; p++) begin : g_rd
        assign rd[p*DATA_W +: DATA_W] = words[ra[p*ADDR_W +: ADDR_W]];
    end
endmodule

// File: rtl/spm_alu.sv
module spm_alu
    import spm_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  op_e               op,
    input  logic [DATA_W-1:0] acc,
    input  logic [DATA_W-1:0] prm,
    input  logic [DATA_W-1:0] opnd,
    output logic [DATA_W-1:0] acc_nxt,
    output logic              acc_pos
);
    always_comb begin
        unique case (op)
            OP_LIT:  acc_nxt = prm;
            OP_ADD:  acc_nxt = acc + opnd;
            OP_SUB:  acc_nxt = acc - opnd;
            default: acc_nxt = acc;
        endcase
    end

    assign acc_pos = !acc[DATA_W-1] && (|acc);
endmodule

// File: rtl/spm_seq.sv
module spm_seq
    import spm_pkg::*;
#(
    parameter int DATA_W     = 16,
    parameter int ADDR_W     = 8,
    parameter int ENTRY_ADDR = 0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] in_data,
    output logic              in_ready,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_data,
    output logic              halted,
    output logic [ADDR_W-1:0] ic_addr,
    output logic [ADDR_W-1:0] prm_addr,
    output logic [ADDR_W-1:0] opnd_addr,
    input  logic [DATA_W-1:0] opw_rd,
    input  logic [DATA_W-1:0] prmw_rd,
    input  logic [DATA_W-1:0] opnd_rd,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_wa,
    output logic [DATA_W-1:0] mem_wd
);
    localparam logic [ADDR_W-1:0] ENTRY = ADDR_W'(ENTRY_ADDR);
    localparam logic [ADDR_W-1:0] STEP  = ADDR_W'(IC_STEP);
    localparam logic signed [DATA_W-1:0] LO = DATA_W'(OPC_MIN);
    localparam logic signed [DATA_W-1:0] HI = DATA_W'(OPC_MAX);

    typedef struct packed {
        logic [DATA_W-1:0] opw;
        logic [DATA_W-1:0] prm;
    } instr_t;

    st_e               st_q;
    instr_t            ins_q;
    logic [ADDR_W-1:0] ic_q;
    logic [DATA_W-1:0] acc_q;
    logic              outv_q;
    logic [DATA_W-1:0] outd_q;

    logic              legal;
    op_e               op;
    logic [ADDR_W-1:0] jaddr;
    logic [ADDR_W-1:0] ic_next_seq;
    logic [DATA_W-1:0] acc_nxt;
    logic              acc_pos;

    assign legal       = ($signed(ins_q.opw) >= LO) && ($signed(ins_q.opw) <= HI);
    assign op          = decode_op(legal, ins_q.opw[2:0]);
    assign jaddr       = ins_q.prm[ADDR_W-1:0];
    assign ic_next_seq = ic_q + STEP;

    assign ic_addr   = ic_q;
    assign prm_addr  = ic_q + ADDR_W'(1);
    assign opnd_addr = jaddr;

    spm_alu #(.DATA_W(DATA_W)) alu_i (
        .op      (op),
        .acc     (acc_q),
        .prm     (ins_q.prm),
        .opnd    (opnd_rd),
        .acc_nxt (acc_nxt),
        .acc_pos (acc_pos)
    );

    always_comb begin
        mem_we   = 1'b0;
        mem_wa   = jaddr;
        mem_wd   = acc_q;
        in_ready = 1'b0;
        if (st_q == ST_EXEC) begin
            if (op == OP_PUT) begin
                mem_we = 1'b1;
            end else if (op == OP_GET) begin
                in_ready = 1'b1;
                mem_we   = in_valid;
                mem_wd   = in_data;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= ST_STOP;
            ins_q  <= '0;
            ic_q   <= ENTRY;
            acc_q  <= '0;
            outv_q <= 1'b0;
            outd_q <= '0;
        end else begin
            outv_q <= 1'b0;
            unique case (st_q)
                ST_STOP: begin
                    if (start) begin
                        ic_q  <= ENTRY;
                        acc_q <= '0;
                        st_q  <= ST_FETCH;
                    end
                end
                ST_FETCH: begin
                    ins_q <= '{opw: opw_rd, prm: prmw_rd};
                    st_q  <= ST_EXEC;
                end
                ST_EXEC: begin
                    unique case (op)
                        OP_LIT, OP_ADD, OP_SUB: begin
                            acc_q <= acc_nxt;
                            ic_q  <= ic_next_seq;
                            st_q  <= ST_FETCH;
                        end
                        OP_PUT: begin
                            ic_q <= ic_next_seq;
                            st_q <= ST_FETCH;
                        end
                        OP_BPOS: begin
                            ic_q <= acc_pos ? jaddr : ic_next_seq;
                            st_q <= ST_FETCH;
                        end
                        OP_GET: begin
                            if (in_valid) begin
                                ic_q <= ic_next_seq;
                                st_q <= ST_FETCH;
                            end
                        end
                        OP_SHOW: begin
                            outv_q <= 1'b1;
                            outd_q <= opnd_rd;
                            ic_q   <= ic_next_seq;
                            st_q   <= ST_FETCH;
                        end
                        default: begin
                            st_q <= ST_STOP;
                        end
                    endcase
                end
                default: st_q <= ST_STOP;
            endcase
        end
    end

    assign out_valid = outv_q;
    assign out_data  = outd_q;
    assign halted    = (st_q == ST_STOP);
endmodule

// File: rtl/spm_top.sv
module spm_top
    import spm_pkg::*;
#(
    parameter int DATA_W     = 16,
    parameter int ADDR_W     = 8,
    parameter int ENTRY_ADDR = 0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              load_en,
    input  logic [ADDR_W-1:0] load_addr,
    input  logic [DATA_W-1:0] load_data,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] in_data,
    output logic              in_ready,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_data,
    output logic              halted
);
    localparam int NRD = 3;

    logic [ADDR_W-1:0] ic_addr, prm_addr, opnd_addr;
    logic [DATA_W-1:0] opw_rd, prmw_rd, opnd_rd;
    logic              seq_we;
    logic [ADDR_W-1:0] seq_wa;
    logic [DATA_W-1:0] seq_wd;
    logic              st_we;
    logic [ADDR_W-1:0] st_wa;
    logic [DATA_W-1:0] st_wd;
    logic              host_wr;
    logic [NRD*ADDR_W-1:0] rd_addr;
    logic [NRD*DATA_W-1:0] rd_data;

    spm_seq #(
        .DATA_W     (DATA_W),
        .ADDR_W     (ADDR_W),
        .ENTRY_ADDR (ENTRY_ADDR)
    ) seq_i (
        .clk       (clk),
        .rst       (rst),
        .start     (start),
        .in_valid  (in_valid),
        .in_data   (in_data),
        .in_ready  (in_ready),
        .out_valid (out_valid),
        .out_data  (out_data),
        .halted    (halted),
        .ic_addr   (ic_addr),
        .prm_addr  (prm_addr),
        .opnd_addr (opnd_addr),
        .opw_rd    (opw_rd),
        .prmw_rd   (prmw_rd),
        .opnd_rd   (opnd_rd),
        .mem_we    (seq_we),
        .mem_wa    (seq_wa),
        .mem_wd    (seq_wd)
    );

    // The loader owns the write port only while the machine is stopped.
    assign host_wr = halted && load_en;
    assign st_we   = host_wr || seq_we;
    assign st_wa   = host_wr ? load_addr : seq_wa;
    assign st_wd   = host_wr ? load_data : seq_wd;

    assign rd_addr = {opnd_addr, prm_addr, ic_addr};
    assign opw_rd  = rd_data[0*DATA_W +: DATA_W];
    assign prmw_rd = rd_data[1*DATA_W +: DATA_W];
    assign opnd_rd = rd_data[2*DATA_W +: DATA_W];

    spm_store #(
        .DATA_W (DATA_W),
        .ADDR_W (ADDR_W),
        .NRD    (NRD)
    ) store_i (
        .clk (clk),
        .we  (st_we),
        .wa  (st_wa),
        .wd  (st_wd),
        .ra  (rd_addr),
        .rd  (rd_data)
    );
endmodule

// File: rtl/spm_chk.sv
module spm_chk (
    input logic clk,
    input logic rst,
    input logic start,
    input logic in_valid,
    input logic in_ready,
    input logic out_valid,
    input logic halted
);
    a_r2_start_runs: assert property (@(posedge clk) disable iff (rst)
        (halted && start) |=> !halted);

    a_r10_stop_holds: assert property (@(posedge clk) disable iff (rst)
        (halted && !start) |=> halted);

    a_r8_ready_waits: assert property (@(posedge clk) disable iff (rst)
        (in_ready && !in_valid) |=> in_ready);

    a_r8_ready_running: assert property (@(posedge clk) disable iff (rst)
        in_ready |-> !halted);

    a_r9_out_pulse: assert property (@(posedge clk) disable iff (rst)
        out_valid |=> !out_valid);
endmodule

bind spm_top spm_chk chk_i (
    .clk       (clk),
    .rst       (rst),
    .start     (start),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .out_valid (out_valid),
    .halted    (halted)
);

// File: tb/spm_top_tb.sv
module spm_top_tb_top;
    localparam int DW = 16;
    localparam int AW = 8;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          start = 1'b0;
    logic          load_en = 1'b0;
    logic [AW-1:0] load_addr = '0;
    logic [DW-1:0] load_data = '0;
    logic          in_valid = 1'b0;
    logic [DW-1:0] in_data = '0;
    logic          in_ready;
    logic          out_valid;
    logic [DW-1:0] out_data;
    logic          halted;

    int total = 0;
    int bad   = 0;
    int ngot  = 0;
    int cyc   = 0;
    logic done = 1'b0;
    logic [DW-1:0] got [16];

    always #4 clk = ~clk;

    spm_top dut_i (
        .clk(clk), .rst(rst), .start(start),
        .load_en(load_en), .load_addr(load_addr), .load_data(load_data),
        .in_valid(in_valid), .in_data(in_data), .in_ready(in_ready),
        .out_valid(out_valid), .out_data(out_data), .halted(halted)
    );

    // Collect printed words; each one-cycle strobe is counted once.
    always @(negedge clk) begin
        if (out_valid) begin
            if (ngot < 16) got[ngot] = out_data;
            ngot = ngot + 1;
        end
    end

    always @(posedge clk) begin
        cyc = cyc + 1;
        if (cyc > 100000 && !done) begin
            done = 1'b1;
            total = total + 1;
            bad = bad + 1;
            $display("FAIL watchdog act=%0d exp=<100000", cyc);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    // {a, b, sum, diff, third output expected}
    localparam logic [79:0] VEC [6] = '{
        {16'd10,    16'd3,    16'd13,    16'd7,     16'd1},
        {16'd3,     16'd10,   16'd13,    16'hFFF9,  16'd0},
        {16'd4,     16'd4,    16'd8,     16'd0,     16'd0},
        {16'h7FFF,  16'd1,    16'h8000,  16'h7FFE,  16'd1},
        {16'h8000,  16'd1,    16'h8001,  16'h7FFF,  16'd1},
        {16'hFFFF,  16'hFFFF, 16'hFFFE,  16'd0,     16'd0}
    };

    task automatic check(input logic ok, input string tag, input int act, input int exp);
        total = total + 1;
        if (!ok) begin
            bad = bad + 1;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input int a, input int d);
        load_en = 1'b1; load_addr = AW'(a); load_data = DW'(d);
        @(negedge clk);
        load_en = 1'b0;
    endtask

    task automatic ins(input int a, input int op, input int prm);
        wr(a, op);
        wr(a + 1, prm);
    endtask

    task automatic go();
        ngot = 0;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic send(input logic [DW-1:0] v);
        in_valid = 1'b1; in_data = v;
        while (!in_ready) @(negedge clk);
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic wait_stop(input string tag);
        int n = 0;
        while (!halted && n < 2000) begin
            @(negedge clk);
            n++;
        end
        check(halted, tag, halted, 1);
    endtask

    task automatic arith_prog();
        ins(0, 6, 100);   ins(2, 6, 101);   ins(4, 2, 100);   ins(6, 2, 101);
        ins(8, 4, 102);   ins(10, 7, 102);  ins(12, 1, 0);    ins(14, 2, 100);
        ins(16, 3, 101);  ins(18, 4, 103);  ins(20, 7, 103);  ins(22, 5, 26);
        ins(24, 0, 0);    ins(26, 1, 1);    ins(28, 4, 104);  ins(30, 7, 104);
        ins(32, 0, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        check(halted == 1'b1, "R1 halted", halted, 1);
        check(out_valid == 1'b0, "R1 out_valid", out_valid, 0);
        check(in_ready == 1'b0, "R1 in_ready", in_ready, 0);

        arith_prog();

        // Vector table: R3 R5 R6 R7 R8 R9, and R2 (each run relies on a cleared accumulator)
        for (int i = 0; i < 6; i++) begin
            logic [DW-1:0] a, b, s, d, f;
            {a, b, s, d, f} = VEC[i];
            go();
            check(!halted, "R2 running after start", halted, 0);
            send(a);
            send(b);
            wait_stop("R10 stop at end");
            check(ngot == 2 + int'(f), "R7 output count", ngot, 2 + int'(f));
            check(got[0] == s, "R5 sum", got[0], s);
            check(got[1] == d, "R5 difference", got[1], d);
            if (f != 0) check(got[2] == 16'd1, "R4 literal after branch", got[2], 1);
        end

        // R8 stall and R12 loader ignored while running
        go();
        repeat (20) @(negedge clk);
        check(in_ready == 1'b1, "R8 ready during stall", in_ready, 1);
        check(ngot == 0 && !halted, "R8 no progress in stall", ngot, 0);
        wr(2, 0);
        send(16'd10);
        send(16'd3);
        wait_stop("R12 run completes");
        check(ngot == 3, "R12 load ignored while running", ngot, 3);
        check(got[0] == 16'd13, "R12 program intact", got[0], 13);

        // R11 self-modification through read and store
        ins(0, 6, 7);   ins(2, 1, 0);   ins(4, 1, 0);   ins(6, 7, 51);
        ins(8, 1, 52);  ins(10, 4, 13); ins(12, 7, 51); ins(14, 0, 0);
        wr(50, 1234); wr(51, 999); wr(52, 4321);
        go();
        send(16'd50);
        wait_stop("R11 stop");
        check(ngot == 2, "R11 count", ngot, 2);
        check(got[0] == 16'd1234, "R11 read into parameter", got[0], 1234);
        check(got[1] == 16'd4321, "R11 store into parameter (R6)", got[1], 4321);

        // R10 halting opcodes, with 7 legal and 8 / -1 stopping
        ins(0, 7, 60); ins(2, 16'hFFFF, 61); ins(4, 7, 61); ins(6, 0, 0);
        wr(60, 5); wr(61, 6);
        go();
        wait_stop("R10 negative stop");
        check(ngot == 1 && got[0] == 16'd5, "R10 negative opcode halts", ngot, 1);
        wr(2, 8);
        go();
        wait_stop("R10 opcode 8 stop");
        check(ngot == 1, "R10 opcode 8 halts", ngot, 1);
        wr(2, 7);
        go();
        wait_stop("R10 opcode 7 legal");
        check(ngot == 3 && got[1] == 16'd6 && got[2] == 16'd6, "R9 opcode 7 prints", ngot, 3);

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule